// File: doc/BRIEF.md
# Segmented Stream Framing Monitor

This block watches a segmented streaming bus without driving it. Each beat carries eight 128-bit segments. Every segment has its own sideband: an enable, a start flag, an end flag, an error flag and a 4-bit count of empty bytes. Up to four ports share the segment lines, and each port has its own valid/ready pair. A beat counts only when a port's valid and ready are both high. A 6-bit channel identifier travels with each beat.

On each accepted beat the monitor walks the enabled segments in ascending order. It carries an open/closed packet state for the (port, channel) pair that owns the beat. It reports the first framing violation it finds as a code, the segment index and the port, and it pulses a strobe. It also keeps running totals of completed packets, errored packets and payload bytes. A flush input per port clears the open state of one channel, so that recovery can happen without a full reset. Payload data is not inspected, so the data lines are not an input.

Top module: `segstream_monitor`

## Requirements
- R1: A beat is accepted when `(seg_tvalid & seg_tready)` is non-zero, and the lowest-numbered such port owns it. Results appear at the outputs on the clock edge after the beat. `viol_strobe` is high for exactly that one cycle, and only when `viol_code` is non-zero. Without an accepted beat the counters hold and the strobe stays low.
- R2: A segment whose enable bit is 0 has no effect: its start, end, error and empty-count bits change no state, count nothing and raise no violation.
- R3: An enabled segment with start=0 and end=0 that arrives while the packet is closed raises code 1 (missing start). The packet stays closed.
- R4: An enabled segment with start=1 while the packet is open raises code 2 (duplicate start). The packet stays open as a new packet.
- R5: An enabled segment with end=1 and start=0 while the packet is closed raises code 3 (end without start). It adds nothing to the packet count.
- R6: An enabled segment with a non-zero empty count and end=0 raises code 4 (misused empty count).
- R7: An enabled segment with error=1 and end=0 raises code 5 (error flag outside an end segment).
- R8: Segments are processed from index 0 up to 7, and each one sees the state the previous one left behind. The reported violation is the one in the lowest-indexed offending segment, and `viol_seg` gives that index. Within one segment, codes 1/2/3 win over code 4, and code 4 wins over code 5.
- R9: An enabled end segment that closes an open packet adds 1 to `pkt_cnt`. If its error bit is 1, it also adds 1 to `err_pkt_cnt`.
- R10: Every enabled segment adds to `byte_cnt`, whether or not it raised a violation. An end segment adds 16 minus its empty count; any other enabled segment adds 16.
- R11: Open state is kept separately for every (port, channel) pair, so traffic on one pair never changes another pair's state.
- R12: When `chan_flush[p]` is high, the open state of (p, `seg_tid`) is cleared in that cycle. A beat on the same pair in the same cycle starts from the closed state.
- R13: After the synchronous active-low reset, all counters are 0, the strobe and code are 0, and every pair is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_tvalid | input | 4 | Valid per port |
| seg_tready | input | 4 | Ready per port (observed only) |
| seg_tid | input | 6 | Channel of the current beat; also selects the pair to flush |
| seg_ena | input | 8 | Enable per segment |
| seg_sop | input | 8 | Start flag per segment |
| seg_eop | input | 8 | End flag per segment |
| seg_err | input | 8 | Error flag per segment |
| seg_mty | input | 32 | Empty-byte count, 4 bits per segment, segment i at bits [4i+3:4i] |
| chan_flush | input | 4 | Flush per port for channel `seg_tid` |
| viol_strobe | output | 1 | One-cycle pulse when a violation is reported |
| viol_code | output | 3 | 0 none, 1 missing start, 2 duplicate start, 3 end without start, 4 empty count misuse, 5 error outside end |
| viol_seg | output | 3 | Segment index of the reported violation |
| viol_port | output | 2 | Port that owned the offending beat |
| pkt_cnt | output | 32 | Completed packets |
| err_pkt_cnt | output | 32 | Completed packets marked bad |
| byte_cnt | output | 48 | Payload bytes on enabled segments |

## Verification
The bound checker watches the invariants that hold on every cycle:
- the strobe only ever follows an accepted beat, and it agrees with a non-zero code;
- counters hold when no beat is accepted;
- the errored-packet count never passes the packet count;
- no single beat moves a counter by more than eight segments' worth.

Only the directed scenarios can show the specific violation codes and their priority across and within segments. The same goes for byte totals that depend on the empty counts, the independence of the (port, channel) pairs, and the ordering of a flush against a beat in the same cycle.

// File: rtl/ssm_pkg.sv
// Package: shared violation codes for the segmented stream monitor.
// Assumes a 3-bit code is wide enough for all framing violation kinds.
package ssm_pkg;
    typedef enum logic [2:0] {
        VIOL_NONE     = 3'd0,
        VIOL_NO_START = 3'd1,
        VIOL_DUP_SOP  = 3'd2,
        VIOL_EOP_ONLY = 3'd3,
        VIOL_BAD_MTY  = 3'd4,
        VIOL_ERR_MID  = 3'd5
    } viol_e;
endpackage

// File: rtl/ssm_port_pick.sv
// Module: picks the port that owns the current beat.
// Assumes normally at most one port hands over a beat per cycle; when
// several do, the lowest index wins.
module ssm_port_pick #(
    parameter int NUM_PORT = 4,
    localparam int PORT_W = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1
) (
    input  logic [NUM_PORT-1:0] valid,
    input  logic [NUM_PORT-1:0] ready,
    output logic                beat,
    output logic [PORT_W-1:0]   port
);
    logic [NUM_PORT-1:0] xfer;
    assign xfer = valid & ready;
    assign beat = |xfer;

    // Priority scan from the top so the lowest set index is kept last.
    always_comb begin
        port = '0;
        for (int p = NUM_PORT - 1; p >= 0; p--) begin
            if (xfer[p]) port = PORT_W'(p);
        end
    end
endmodule

// File: rtl/ssm_open_table.sv
// Module: open/closed packet flag for each (port, channel) pair.
// Assumes flush addresses channel `tid` on every flagged port and takes
// effect before the beat's write in the same cycle.
module ssm_open_table #(
    parameter int NUM_PORT = 4,
    parameter int CH_W     = 6,
    localparam int PORT_W  = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1,
    localparam int NUM_CH  = 1 << CH_W,
    localparam int DEPTH   = NUM_PORT * NUM_CH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PORT-1:0] flush,
    input  logic [CH_W-1:0]     tid,
    input  logic                beat,
    input  logic [PORT_W-1:0]   port,
    input  logic                open_wr,
    output logic                open_rd
);
    logic [DEPTH-1:0] open_q;
    int               rd_idx;

    // Read the owning pair; a same-cycle flush makes it look closed.
    always_comb begin
        rd_idx  = int'(port) * NUM_CH + int'(tid);
        open_rd = open_q[rd_idx] && !flush[port];
    end

    // Apply flushes first, then the beat's resulting state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '0;
        end else begin
            for (int p = 0; p < NUM_PORT; p++) begin
                if (flush[p]) open_q[p * NUM_CH + int'(tid)] <= 1'b0;
            end
            if (beat) open_q[rd_idx] <= open_wr;
        end
    end
endmodule

// File: rtl/ssm_seg_walk.sv
// Module: walks the segments of one beat from index 0 upward.
// Carries the open state from one segment to the next, finds the first
// violation and sums the packet, errored-packet and byte increments.
// Assumes purely combinational use within one cycle.
module ssm_seg_walk
    import ssm_pkg::*;
#(
    parameter int NUM_SEG   = 8,
    parameter int SEG_BYTES = 16,
    localparam int MTY_W    = $clog2(SEG_BYTES),
    localparam int IDX_W    = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int INC_W    = $clog2(NUM_SEG + 1),
    localparam int SUM_W    = $clog2(NUM_SEG * SEG_BYTES + 1)
) (
    input  logic                     open_in,
    input  logic [NUM_SEG-1:0]       ena,
    input  logic [NUM_SEG-1:0]       sop,
    input  logic [NUM_SEG-1:0]       eop,
    input  logic [NUM_SEG-1:0]       err,
    input  logic [NUM_SEG*MTY_W-1:0] mty,
    output logic                     open_out,
    output viol_e                    first_code,
    output logic [IDX_W-1:0]         first_seg,
    output logic [INC_W-1:0]         pkt_inc,
    output logic [INC_W-1:0]         err_inc,
    output logic [SUM_W-1:0]         byte_sum
);
    logic [NUM_SEG:0]   open_c;
    viol_e              code_s  [NUM_SEG];
    logic [NUM_SEG-1:0] close_s;
    logic [SUM_W-1:0]   bytes_s [NUM_SEG];

    assign open_c[0] = open_in;
    assign open_out  = open_c[NUM_SEG];

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        viol_e            code_l;
        logic             next_l;
        logic             close_l;
        logic [MTY_W-1:0] mty_l;
        assign mty_l = mty[i*MTY_W +: MTY_W];

        // Classify one segment against the state left by the previous one.
        always_comb begin
            code_l  = VIOL_NONE;
            next_l  = open_c[i];
            close_l = 1'b0;
            if (ena[i]) begin
                if (sop[i]) begin
                    if (open_c[i]) code_l = VIOL_DUP_SOP;
                    next_l = 1'b1;
                end else if (!open_c[i]) begin
                    code_l = eop[i] ? VIOL_EOP_ONLY : VIOL_NO_START;
                end
                if (code_l == VIOL_NONE && mty_l != '0 && !eop[i]) code_l = VIOL_BAD_MTY;
                if (code_l == VIOL_NONE && err[i] && !eop[i])      code_l = VIOL_ERR_MID;
                if (eop[i]) begin
                    close_l = next_l;
                    next_l  = 1'b0;
                end
            end
        end

        assign open_c[i+1] = next_l;
        assign code_s[i]   = code_l;
        assign close_s[i]  = close_l;
        assign bytes_s[i]  = !ena[i] ? '0 :
                             eop[i]  ? SUM_W'(SEG_BYTES) - SUM_W'(mty_l) : SUM_W'(SEG_BYTES);
    end

    // Keep the lowest-indexed violation by scanning downward.
    always_comb begin
        first_code = VIOL_NONE;
        first_seg  = '0;
        for (int i = NUM_SEG - 1; i >= 0; i--) begin
            if (code_s[i] != VIOL_NONE) begin
                first_code = code_s[i];
                first_seg  = IDX_W'(i);
            end
        end
    end

    // Sum per-segment increments for the counters.
    always_comb begin
        pkt_inc  = '0;
        err_inc  = '0;
        byte_sum = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            pkt_inc  = pkt_inc + INC_W'(close_s[i]);
            err_inc  = err_inc + INC_W'(close_s[i] & err[i]);
            byte_sum = byte_sum + bytes_s[i];
        end
    end
endmodule

// File: rtl/segstream_monitor.sv
// Module: passive framing monitor for a segmented multi-port stream bus.
// Tracks an open packet per (port, channel) and reports the first violation
// of each accepted beat one cycle later. Counts packets, errored packets
// and bytes. Assumes the bus is only observed; ready is an input.
module segstream_monitor
    import ssm_pkg::*;
#(
    parameter int NUM_PORT  = 4,
    parameter int NUM_SEG   = 8,
    parameter int SEG_W     = 128,
    parameter int CH_W      = 6,
    parameter int CNT_W     = 32,
    parameter int BYTE_W    = 48,
    localparam int SEG_BYTES = SEG_W / 8,
    localparam int MTY_W     = $clog2(SEG_BYTES),
    localparam int PORT_W    = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1,
    localparam int IDX_W     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int INC_W     = $clog2(NUM_SEG + 1),
    localparam int SUM_W     = $clog2(NUM_SEG * SEG_BYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PORT-1:0]      seg_tvalid,
    input  logic [NUM_PORT-1:0]      seg_tready,
    input  logic [CH_W-1:0]          seg_tid,
    input  logic [NUM_SEG-1:0]       seg_ena,
    input  logic [NUM_SEG-1:0]       seg_sop,
    input  logic [NUM_SEG-1:0]       seg_eop,
    input  logic [NUM_SEG-1:0]       seg_err,
    input  logic [NUM_SEG*MTY_W-1:0] seg_mty,
    input  logic [NUM_PORT-1:0]      chan_flush,
    output logic                     viol_strobe,
    output logic [2:0]               viol_code,
    output logic [IDX_W-1:0]         viol_seg,
    output logic [PORT_W-1:0]        viol_port,
    output logic [CNT_W-1:0]         pkt_cnt,
    output logic [CNT_W-1:0]         err_pkt_cnt,
    output logic [BYTE_W-1:0]        byte_cnt
);
    logic              beat;
    logic [PORT_W-1:0] port;
    logic              open_rd;
    logic              open_wr;
    viol_e             code;
    logic [IDX_W-1:0]  seg_idx;
    logic [INC_W-1:0]  pkt_inc;
    logic [INC_W-1:0]  err_inc;
    logic [SUM_W-1:0]  byte_sum;

    ssm_port_pick #(.NUM_PORT(NUM_PORT)) pick_i (
        .valid (seg_tvalid),
        .ready (seg_tready),
        .beat  (beat),
        .port  (port)
    );

    ssm_open_table #(.NUM_PORT(NUM_PORT), .CH_W(CH_W)) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (chan_flush),
        .tid     (seg_tid),
        .beat    (beat),
        .port    (port),
        .open_wr (open_wr),
        .open_rd (open_rd)
    );

    ssm_seg_walk #(.NUM_SEG(NUM_SEG), .SEG_BYTES(SEG_BYTES)) walk_i (
        .open_in    (open_rd),
        .ena        (seg_ena),
        .sop        (seg_sop),
        .eop        (seg_eop),
        .err        (seg_err),
        .mty        (seg_mty),
        .open_out   (open_wr),
        .first_code (code),
        .first_seg  (seg_idx),
        .pkt_inc    (pkt_inc),
        .err_inc    (err_inc),
        .byte_sum   (byte_sum)
    );

    // Register the violation report; the strobe lasts one cycle per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_strobe <= 1'b0;
            viol_code   <= VIOL_NONE;
            viol_seg    <= '0;
            viol_port   <= '0;
        end else begin
            viol_strobe <= beat && (code != VIOL_NONE);
            viol_code   <= beat ? code : VIOL_NONE;
            if (beat && code != VIOL_NONE) begin
                viol_seg  <= seg_idx;
                viol_port <= port;
            end
        end
    end

    // Accumulate packet, errored-packet and byte totals on accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_cnt     <= '0;
            err_pkt_cnt <= '0;
            byte_cnt    <= '0;
        end else if (beat) begin
            pkt_cnt     <= pkt_cnt + CNT_W'(pkt_inc);
            err_pkt_cnt <= err_pkt_cnt + CNT_W'(err_inc);
            byte_cnt    <= byte_cnt + BYTE_W'(byte_sum);
        end
    end
endmodule

// File: rtl/segstream_monitor_checker.sv
// Module: cycle-level invariants of the framing monitor, bound to its top.
// Assumes the top's default port widths are reflected through parameters.
module segstream_monitor_checker #(
    parameter int NUM_PORT  = 4,
    parameter int NUM_SEG   = 8,
    parameter int SEG_W     = 128,
    parameter int CNT_W     = 32,
    parameter int BYTE_W    = 48
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PORT-1:0] seg_tvalid,
    input logic [NUM_PORT-1:0] seg_tready,
    input logic                viol_strobe,
    input logic [2:0]          viol_code,
    input logic [CNT_W-1:0]    pkt_cnt,
    input logic [CNT_W-1:0]    err_pkt_cnt,
    input logic [BYTE_W-1:0]   byte_cnt
);
    logic any_beat;
    assign any_beat = |(seg_tvalid & seg_tready);

    // R1: a report only follows an accepted beat.
    assert_strobe_after_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        viol_strobe |-> $past(any_beat));

    // R1: strobe and non-zero code agree.
    assert_strobe_code_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
        viol_strobe == (viol_code != 3'd0));

    // R1: no beat, no counter change and no report.
    assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_beat |=> ($stable(pkt_cnt) && $stable(err_pkt_cnt) && $stable(byte_cnt) && !viol_strobe));

    // R9: errored packets are a subset of packets.
    assert_err_within_pkts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pkt_cnt <= pkt_cnt);

    // R9: one beat closes at most one packet per segment.
    assert_pkt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt - $past(pkt_cnt)) <= CNT_W'(NUM_SEG));

    // R10: one beat adds at most a full beat of bytes.
    assert_byte_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cnt - $past(byte_cnt)) <= BYTE_W'(NUM_SEG * (SEG_W / 8)));
endmodule

bind segstream_monitor segstream_monitor_checker #(
    .NUM_PORT (NUM_PORT),
    .NUM_SEG  (NUM_SEG),
    .SEG_W    (SEG_W),
    .CNT_W    (CNT_W),
    .BYTE_W   (BYTE_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .seg_tvalid  (seg_tvalid),
    .seg_tready  (seg_tready),
    .viol_strobe (viol_strobe),
    .viol_code   (viol_code),
    .pkt_cnt     (pkt_cnt),
    .err_pkt_cnt (err_pkt_cnt),
    .byte_cnt    (byte_cnt)
);

// File: tb/segstream_monitor_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the segmented stream framing monitor.
module segstream_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tvalid = '0;
    logic [3:0]  tready = '0;
    logic [5:0]  tid = '0;
    logic [7:0]  ena = '0, sop = '0, eop = '0, err = '0;
    logic [31:0] mty = '0;
    logic [3:0]  flush = '0;
    logic        viol_strobe;
    logic [2:0]  viol_code;
    logic [2:0]  viol_seg;
    logic [1:0]  viol_port;
    logic [31:0] pkt_cnt, err_pkt_cnt;
    logic [47:0] byte_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    longint exp_pkt = 0, exp_err = 0, exp_bytes = 0;

    always #2.5 clk = ~clk;

    segstream_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .seg_tvalid(tvalid), .seg_tready(tready),
        .seg_tid(tid), .seg_ena(ena), .seg_sop(sop), .seg_eop(eop),
        .seg_err(err), .seg_mty(mty), .chan_flush(flush),
        .viol_strobe(viol_strobe), .viol_code(viol_code), .viol_seg(viol_seg),
        .viol_port(viol_port), .pkt_cnt(pkt_cnt), .err_pkt_cnt(err_pkt_cnt),
        .byte_cnt(byte_cnt)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_segs();
        ena = '0; sop = '0; eop = '0; err = '0; mty = '0;
    endtask

    task automatic set_seg(input int i, input logic e, input logic s,
                           input logic f, input logic x, input logic [3:0] m);
        ena[i] = e; sop[i] = s; eop[i] = f; err[i] = x; mty[i*4 +: 4] = m;
    endtask

    // Drive one cycle at a falling edge, then return at the next falling edge.
    task automatic drive(input logic [3:0] v, input logic [3:0] r,
                         input logic [5:0] t, input logic [3:0] fl);
        tvalid = v; tready = r; tid = t; flush = fl;
        @(negedge clk);
        tvalid = '0; tready = '0; flush = '0;
        clear_segs();
    endtask

    task automatic expect_viol(input string req, input logic s, input logic [2:0] c,
                               input logic [2:0] sg, input logic [1:0] p);
        chk({req, " strobe"}, viol_strobe, s);
        chk({req, " code"}, viol_code, s ? c : 3'd0);
        if (s) begin
            chk({req, " seg"}, viol_seg, sg);
            chk({req, " port"}, viol_port, p);
        end
    endtask

    task automatic expect_cnt(input string req);
        chk({req, " pkt_cnt"}, pkt_cnt, exp_pkt);
        chk({req, " err_pkt_cnt"}, err_pkt_cnt, exp_err);
        chk({req, " byte_cnt"}, byte_cnt, exp_bytes);
    endtask

    task automatic t_reset();
        expect_viol("R13 reset", 1'b0, 3'd0, 3'd0, 2'd0);
        expect_cnt("R13 reset");
    endtask

    // Two clean packets plus idle segments full of junk sideband.
    task automatic t_clean();
        clear_segs();
        set_seg(0, 1, 1, 0, 0, 0);
        set_seg(1, 1, 0, 0, 0, 0);
        set_seg(2, 1, 0, 1, 0, 3);
        set_seg(3, 1, 1, 1, 1, 0);
        for (int i = 4; i < 8; i++) set_seg(i, 0, 1, 1, 1, 4'hF);
        drive(4'b0001, 4'b0001, 6'd5, 4'b0000);
        exp_pkt += 2; exp_err += 1; exp_bytes += 61;
        expect_viol("R2 idle junk ignored", 1'b0, 0, 0, 0);
        expect_cnt("R9 R10 clean packets");
    endtask

    task automatic t_missing_start();
        clear_segs();
        set_seg(0, 1, 0, 0, 0, 0);
        drive(4'b0001, 4'b0001, 6'd5, 4'b0000);
        exp_bytes += 16;
        expect_viol("R3 missing start", 1'b1, 3'd1, 3'd0, 2'd0);
        expect_cnt("R3 missing start");
        @(negedge clk);
        expect_viol("R1 strobe one cycle", 1'b0, 0, 0, 0);
    endtask

    task automatic t_dup_start();
        clear_segs();
        set_seg(0, 1, 1, 0, 0, 0);
        set_seg(1, 1, 1, 1, 0, 0);
        drive(4'b0001, 4'b0001, 6'd5, 4'b0000);
        exp_pkt += 1; exp_bytes += 32;
        expect_viol("R4 duplicate start", 1'b1, 3'd2, 3'd1, 2'd0);
        expect_cnt("R4 duplicate start");
    endtask

    task automatic t_eop_only();
        clear_segs();
        set_seg(0, 1, 0, 1, 1, 2);
        drive(4'b0001, 4'b0001, 6'd5, 4'b0000);
        exp_bytes += 14;
        expect_viol("R5 end without start", 1'b1, 3'd3, 3'd0, 2'd0);
        expect_cnt("R5 end without start");
    endtask

    task automatic t_bad_mty();
        clear_segs();
        set_seg(0, 1, 1, 0, 0, 1);
        set_seg(1, 1, 0, 1, 0, 0);
        drive(4'b0001, 4'b0001, 6'd5, 4'b0000);
        exp_pkt += 1; exp_bytes += 32;
        expect_viol("R6 empty count misuse", 1'b1, 3'd4, 3'd0, 2'd0);
        expect_cnt("R6 empty count misuse");
    endtask

    task automatic t_err_mid();
        clear_segs();
        set_seg(0, 1, 1, 1, 0, 0);
        set_seg(1, 1, 1, 0, 1, 0);
        drive(4'b0001, 4'b0001, 6'd5, 4'b0000);
        exp_pkt += 1; exp_bytes += 32;
        expect_viol("R7 error outside end", 1'b1, 3'd5, 3'd1, 2'd0);
        expect_cnt("R7 error outside end");
        clear_segs();
        set_seg(0, 1, 0, 1, 0, 0);
        drive(4'b0001, 4'b0001, 6'd5, 4'b0000);
        exp_pkt += 1; exp_bytes += 16;
        expect_viol("R7 packet still open", 1'b0, 0, 0, 0);
        expect_cnt("R7 close after error");
    endtask

    task automatic t_priority();
        clear_segs();
        set_seg(1, 1, 0, 0, 1, 2);
        set_seg(3, 1, 1, 0, 0, 0);
        set_seg(4, 1, 1, 0, 0, 0);
        drive(4'b0001, 4'b0001, 6'd5, 4'b0000);
        exp_bytes += 48;
        expect_viol("R8 lowest segment first", 1'b1, 3'd1, 3'd1, 2'd0);
        clear_segs();
        set_seg(0, 1, 0, 1, 0, 0);
        drive(4'b0001, 4'b0001, 6'd5, 4'b0000);
        exp_pkt += 1; exp_bytes += 16;
        expect_viol("R8 state carried across segments", 1'b0, 0, 0, 0);
        expect_cnt("R8 priority");
    endtask

    task automatic t_pairs();
        clear_segs(); set_seg(0, 1, 1, 0, 0, 0);
        drive(4'b0010, 4'b0010, 6'd7, 4'b0000);
        exp_bytes += 16;
        clear_segs(); set_seg(0, 1, 0, 0, 0, 0);
        drive(4'b0001, 4'b0001, 6'd7, 4'b0000);
        exp_bytes += 16;
        expect_viol("R11 other port closed", 1'b1, 3'd1, 3'd0, 2'd0);
        clear_segs(); set_seg(0, 1, 0, 0, 0, 0);
        drive(4'b0010, 4'b0010, 6'd8, 4'b0000);
        exp_bytes += 16;
        expect_viol("R11 other channel closed", 1'b1, 3'd1, 3'd0, 2'd1);
        clear_segs(); set_seg(0, 1, 0, 1, 0, 0);
        drive(4'b0010, 4'b0010, 6'd7, 4'b0000);
        exp_pkt += 1; exp_bytes += 16;
        expect_viol("R11 pair kept open", 1'b0, 0, 0, 0);
        clear_segs(); set_seg(0, 1, 0, 0, 0, 0);
        drive(4'b0101, 4'b0101, 6'd9, 4'b0000);
        exp_bytes += 16;
        expect_viol("R1 lowest port owns beat", 1'b1, 3'd1, 3'd0, 2'd0);
        expect_cnt("R11 pairs");
    endtask

    task automatic t_flush();
        clear_segs(); set_seg(0, 1, 1, 0, 0, 0);
        drive(4'b0100, 4'b0100, 6'd3, 4'b0000);
        exp_bytes += 16;
        drive(4'b0000, 4'b0000, 6'd3, 4'b0100);
        clear_segs(); set_seg(0, 1, 0, 1, 0, 0);
        drive(4'b0100, 4'b0100, 6'd3, 4'b0000);
        exp_bytes += 16;
        expect_viol("R12 flush closes pair", 1'b1, 3'd3, 3'd0, 2'd2);
        clear_segs(); set_seg(0, 1, 1, 0, 0, 0);
        drive(4'b0100, 4'b0100, 6'd3, 4'b0000);
        exp_bytes += 16;
        clear_segs(); set_seg(0, 1, 0, 0, 0, 0);
        drive(4'b0100, 4'b0100, 6'd3, 4'b0100);
        exp_bytes += 16;
        expect_viol("R12 flush before same-cycle beat", 1'b1, 3'd1, 3'd0, 2'd2);
        expect_cnt("R12 flush");
    endtask

    task automatic t_no_handshake();
        clear_segs(); set_seg(0, 1, 0, 0, 0, 5);
        drive(4'b0001, 4'b0000, 6'd5, 4'b0000);
        expect_viol("R1 valid without ready ignored", 1'b0, 0, 0, 0);
        expect_cnt("R1 valid without ready ignored");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_missing_start();
        t_dup_start();
        t_eop_only();
        t_bad_mty();
        t_err_mid();
        t_priority();
        t_pairs();
        t_flush();
        t_no_handshake();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule